// File: doc/BRIEF.md
# SCL Phase Timer with Separate Low and High Periods

This block times the serial clock of a two-wire bus master. It produces the open-drain SCL pull-down and two single-cycle strobes for the byte engine. One strobe marks the moment to change SDA while SCL is low. The other marks the moment to sample SDA while SCL is high. The low and high phases are timed independently, each by a 9-bit count of system clock cycles. Software computes both counts from the clock rate and the bus rate. A 5:4 low:high split gives the usual 100 kHz timing.

Each count is assembled from an 8-bit period byte and one extension bit. The extension bits sit in a separate control byte: bit 7 extends the low count and bit 6 extends the high count. Both counts are captured when a transfer starts from idle. The high phase is timed only while SCL is sensed high, so a slave that stretches the clock lengthens it. The byte engine can hold SCL low at the end of a low phase. Dropping the channel enable returns the timer to idle at once.

Top module: `scl_phase_timer`

## Requirements
- R1: While the clock runs, SCL is pulled low (`scl_drive_low`=1) for exactly L system cycles per low phase. L is `{ictl[7], lo_cnt_lsb}`.
- R2: The high phase lasts exactly H cycles when SCL is not stretched. H is `{ictl[6], hi_cnt_lsb}`. Bits 5..0 of `ictl` have no effect on timing.
- R3: A low or high count below 2 behaves as a count of 2.
- R4: `drive_stb` pulses once per low phase, in low cycle floor(L/2) counting from 0. `sample_stb` pulses once per high phase, in high cycle floor(H/2), counting only cycles in which `scl_in` is high. The two strobes are never high together.
- R5: During the high phase, cycles in which `scl_in` is low do not advance the high count. A stretch of N cycles at the start of the high phase makes it H+N cycles long and delays `sample_stb` by N.
- R6: If `hold_low` is high in the last cycle of a low phase, SCL stays low and no further `drive_stb` is issued. The low phase ends one cycle after the first cycle in which `hold_low` is seen low.
- R7: When `chan_en` is low, the timer is idle from the next cycle. In that state SCL is released and no strobe fires. After re-enabling, a transfer starts with a complete fresh low phase.
- R8: Both counts are captured when a transfer starts from idle. Changes to `lo_cnt_lsb`, `hi_cnt_lsb` or `ictl` during a transfer only take effect at the next start.
- R9: After reset, and whenever `xfer_req` is low at the end of a high phase, the timer idles with SCL released and no strobes. With `xfer_req` high in idle, the first low phase begins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable; low forces idle |
| xfer_req | input | 1 | Byte engine requests a running clock |
| hold_low | input | 1 | Byte engine asks to keep SCL low at the end of the low phase |
| lo_cnt_lsb | input | 8 | Low-phase count, bits 7..0 |
| hi_cnt_lsb | input | 8 | High-phase count, bits 7..0 |
| ictl | input | 8 | Control byte: bit 7 is low-count bit 8, bit 6 is high-count bit 8 |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| drive_stb | output | 1 | One-cycle strobe: change SDA now |
| sample_stb | output | 1 | One-cycle strobe: sample SDA now |

## Verification
The critical coincidence is a hold request landing in the very cycle that ends the low phase while the drive strobe is due in that same cycle. This happens with a low count of 2, where the mid-point and the last cycle coincide. The bench raises `hold_low` before that cycle and keeps it up for several cycles. It then requires exactly one `drive_stb` and a low phase stretched to the release point. A second case overlaps a slave stretch with the point where the high count would otherwise reach its middle. There the sample strobe must move late by the stretch length and still appear only once.

// File: rtl/scl_gen_pkg.sv
// Package: shared types and constants for the SCL phase timer.
// Assumes: included first in compile order.
package scl_gen_pkg;

    // Phase of the generated serial clock.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    // Shortest phase the timer will produce, in system cycles.
    localparam int unsigned MIN_PHASE = 2;

endpackage

// File: rtl/scl_count_latch.sv
// Module: captures one phase count at transfer start and clamps it to the
// minimum phase width.
// Assumes: load is a single-cycle pulse from the phase FSM.
module scl_count_latch
    import scl_gen_pkg::*;
#(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] raw,
    output logic [CNT_W-1:0] eff
);

    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_PHASE);

    logic [CNT_W-1:0] eff_q;

    // Purpose: hold the clamped count between transfer starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_q <= FLOOR;
        end else if (load) begin
            eff_q <= (raw < FLOOR) ? FLOOR : raw;
        end
    end

    assign eff = eff_q;

    assert_min_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eff_q >= FLOOR);

    assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(eff_q));

endmodule

// File: rtl/scl_tick_counter.sv
// Module: cycle counter for the current phase. It clears or increments on
// command from the phase FSM.
// Assumes: clr has priority over inc.
module scl_tick_counter #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: count cycles spent in the present phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign cnt = cnt_q;

    assert_cnt_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/scl_phase_fsm.sv
// Module: sequences idle, low and high phases. It drives the counter and
// the count capture, and decodes the two mid-phase strobes.
// Assumes: scl_in is already synchronised to clk; lo_eff and hi_eff are >= 2.
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             xfer_req,
    input  logic             hold_low,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] lo_eff,
    input  logic [CNT_W-1:0] hi_eff,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             cfg_load,
    output logic             scl_drive_low,
    output logic             drive_stb,
    output logic             sample_stb
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    scl_phase_e state_q, state_d;
    logic       held_q, held_d;
    logic [CNT_W-1:0] lo_last, hi_last, lo_mid, hi_mid;

    // Purpose: terminal and mid-point values of each phase.
    always_comb begin
        lo_last = lo_eff - ONE;
        hi_last = hi_eff - ONE;
        lo_mid  = lo_eff >> 1;
        hi_mid  = hi_eff >> 1;
    end

    // Purpose: next-phase decision and counter control.
    always_comb begin
        state_d  = state_q;
        held_d   = held_q;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        cfg_load = 1'b0;
        if (!chan_en) begin
            state_d = PH_IDLE;
            held_d  = 1'b0;
            cnt_clr = 1'b1;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    cnt_clr = 1'b1;
                    held_d  = 1'b0;
                    if (xfer_req) begin
                        state_d  = PH_LOW;
                        cfg_load = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (cnt == lo_last) begin
                        if (hold_low) begin
                            held_d = 1'b1;
                        end else begin
                            state_d = PH_HIGH;
                            held_d  = 1'b0;
                            cnt_clr = 1'b1;
                        end
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (scl_in) begin
                        if (cnt == hi_last) begin
                            cnt_clr = 1'b1;
                            state_d = xfer_req ? PH_LOW : PH_IDLE;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = PH_IDLE;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    // Purpose: phase and hold-seen registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // Purpose: line drive and mid-phase strobes.
    always_comb begin
        scl_drive_low = (state_q == PH_LOW);
        drive_stb     = (state_q == PH_LOW) && (cnt == lo_mid) && !held_q;
        sample_stb    = (state_q == PH_HIGH) && scl_in && (cnt == hi_mid);
    end

    assert_disable_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (state_q == PH_IDLE));

    assert_low_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_LOW) |-> (cnt <= lo_last));

    assert_hold_keeps_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && state_q == PH_LOW && cnt == lo_last && hold_low)
            |=> (state_q == PH_LOW));

    assert_stretch_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && state_q == PH_HIGH && !scl_in) |=> $stable(cnt));

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_stb && sample_stb));

    assert_start_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && state_q == PH_IDLE && xfer_req) |=> (state_q == PH_LOW));

endmodule

// File: rtl/scl_phase_timer.sv
// Module: top of the SCL phase timer. It builds the two 9-bit counts from
// their period bytes and control extension bits, captures them, and runs
// the phase FSM.
// Assumes: the extension bit positions lie inside the control byte.
module scl_phase_timer
    import scl_gen_pkg::*;
#(
    parameter int unsigned LSB_W      = 8,
    parameter int unsigned CTL_W      = 8,
    parameter int unsigned LO_EXT_BIT = 7,
    parameter int unsigned HI_EXT_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             xfer_req,
    input  logic             hold_low,
    input  logic [LSB_W-1:0] lo_cnt_lsb,
    input  logic [LSB_W-1:0] hi_cnt_lsb,
    input  logic [CTL_W-1:0] ictl,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             drive_stb,
    output logic             sample_stb
);

    localparam int unsigned CNT_W  = LSB_W + 1;
    localparam int unsigned N_PHASE = 2;

    logic [N_PHASE-1:0][CNT_W-1:0] raw_cnt, eff_cnt;
    logic [CNT_W-1:0] cnt;
    logic cnt_clr, cnt_inc, cfg_load;

    // Purpose: join each period byte with its extension bit.
    always_comb begin
        raw_cnt[0] = {ictl[LO_EXT_BIT], lo_cnt_lsb};
        raw_cnt[1] = {ictl[HI_EXT_BIT], hi_cnt_lsb};
    end

    for (genvar g = 0; g < N_PHASE; g++) begin : g_cfg
        scl_count_latch #(.CNT_W(CNT_W)) u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (cfg_load),
            .raw   (raw_cnt[g]),
            .eff   (eff_cnt[g])
        );
    end

    scl_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .chan_en       (chan_en),
        .xfer_req      (xfer_req),
        .hold_low      (hold_low),
        .scl_in        (scl_in),
        .lo_eff        (eff_cnt[0]),
        .hi_eff        (eff_cnt[1]),
        .cnt           (cnt),
        .cnt_clr       (cnt_clr),
        .cnt_inc       (cnt_inc),
        .cfg_load      (cfg_load),
        .scl_drive_low (scl_drive_low),
        .drive_stb     (drive_stb),
        .sample_stb    (sample_stb)
    );

    initial begin
        assert_ext_bits_R2: assert (LO_EXT_BIT < CTL_W && HI_EXT_BIT < CTL_W
                                    && LO_EXT_BIT != HI_EXT_BIT);
    end

endmodule

// File: tb/sim_scl_phase_timer.sv
`timescale 1ns/100ps
module sim_scl_phase_timer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chan_en = 1'b0, xfer_req = 1'b0, hold_low = 1'b0, stretch = 1'b0;
    logic [7:0] lo_cnt_lsb = 8'd5, hi_cnt_lsb = 8'd4, ictl = 8'h00;
    logic scl_in, scl_drive_low, drive_stb, sample_stb;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    // Wired-AND bus line: master pull-down or slave stretch.
    assign scl_in = ~(scl_drive_low | stretch);

    scl_phase_timer u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .xfer_req(xfer_req),
        .hold_low(hold_low), .lo_cnt_lsb(lo_cnt_lsb), .hi_cnt_lsb(hi_cnt_lsb),
        .ictl(ictl), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
        .drive_stb(drive_stb), .sample_stb(sample_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #0.2;
    endtask

    // Raise the request and stop at the first low-phase sample point.
    task automatic start_xfer();
        xfer_req = 1'b1;
        for (int i = 0; i < 50 && !scl_drive_low; i++) tick();
    endtask

    // Measure one full period starting at the first low sample.
    task automatic measure(input int stretch_n, input int hold_until,
                           output int lo_len, output int lo_idx, output int n_drv,
                           output int hi_len, output int hi_idx, output int n_smp);
        lo_len = 0; lo_idx = -1; n_drv = 0;
        hi_len = 0; hi_idx = -1; n_smp = 0;
        while (scl_drive_low && lo_len < 2000) begin
            if (hold_until > 0) hold_low = (lo_len < hold_until);
            if (drive_stb) begin n_drv++; lo_idx = lo_len; end
            if (sample_stb) n_smp++;
            lo_len++;
            tick();
        end
        hold_low = 1'b0;
        while (!scl_drive_low && hi_len < 2000) begin
            stretch = (hi_len < stretch_n);
            #0.2;
            if (sample_stb) begin n_smp++; hi_idx = hi_len; end
            if (drive_stb) n_drv++;
            hi_len++;
            tick();
        end
        stretch = 1'b0;
    endtask

    task automatic stop_and_idle();
        xfer_req = 1'b0;
        repeat (1200) tick();
    endtask

    task automatic t_reset();
        chk("R9 reset scl", scl_drive_low, 0);
        chk("R9 reset drive_stb", drive_stb, 0);
        chk("R9 reset sample_stb", sample_stb, 0);
    endtask

    task automatic t_basic();
        int a, b, c, d, e, f;
        lo_cnt_lsb = 8'd5; hi_cnt_lsb = 8'd4; ictl = 8'h3F;  // R2: low bits ignored
        start_xfer();
        measure(0, 0, a, b, c, d, e, f);
        chk("R1 low length", a, 5);
        chk("R2 high length", d, 4);
        chk("R4 drive index", b, 2);
        chk("R4 drive count", c, 1);
        chk("R4 sample index", e, 2);
        chk("R4 sample count", f, 1);
        stop_and_idle();
    endtask

    task automatic t_nine_bit();
        int a, b, c, d, e, f;
        lo_cnt_lsb = 8'd3; hi_cnt_lsb = 8'd1; ictl = 8'hFF;
        start_xfer();
        measure(0, 0, a, b, c, d, e, f);
        chk("R1 9-bit low length", a, 259);
        chk("R2 9-bit high length", d, 257);
        chk("R4 9-bit drive index", b, 129);
        chk("R4 9-bit sample index", e, 128);
        stop_and_idle();
    endtask

    task automatic t_clamp();
        int a, b, c, d, e, f;
        lo_cnt_lsb = 8'd0; hi_cnt_lsb = 8'd1; ictl = 8'h00;
        start_xfer();
        measure(0, 0, a, b, c, d, e, f);
        chk("R3 clamped low", a, 2);
        chk("R3 clamped high", d, 2);
        chk("R3 drive index", b, 1);
        chk("R3 sample index", e, 1);
        stop_and_idle();
    endtask

    task automatic t_stretch();
        int a, b, c, d, e, f;
        lo_cnt_lsb = 8'd6; hi_cnt_lsb = 8'd6; ictl = 8'h00;
        start_xfer();
        measure(3, 0, a, b, c, d, e, f);
        chk("R5 stretched high", d, 9);
        chk("R5 late sample index", e, 6);
        chk("R5 sample count", f, 1);
        stop_and_idle();
    endtask

    task automatic t_hold();
        int a, b, c, d, e, f;
        lo_cnt_lsb = 8'd4; hi_cnt_lsb = 8'd4; ictl = 8'h00;
        start_xfer();
        measure(0, 10, a, b, c, d, e, f);
        chk("R6 held low length", a, 11);
        chk("R6 one drive strobe", c, 1);
        chk("R6 high after hold", d, 4);
        // Coincidence: hold arrives in the cycle that is both mid and end.
        lo_cnt_lsb = 8'd2;
        stop_and_idle();
        start_xfer();
        measure(0, 6, a, b, c, d, e, f);
        chk("R6 coincident low length", a, 7);
        chk("R6 coincident drive count", c, 1);
        chk("R6 coincident drive index", b, 1);
        stop_and_idle();
    endtask

    task automatic t_capture();
        int a, b, c, d, e, f;
        lo_cnt_lsb = 8'd5; hi_cnt_lsb = 8'd4; ictl = 8'h00;
        start_xfer();
        measure(0, 0, a, b, c, d, e, f);
        lo_cnt_lsb = 8'd7; hi_cnt_lsb = 8'd3; ictl = 8'hC0;
        measure(0, 0, a, b, c, d, e, f);
        chk("R8 low unchanged", a, 5);
        chk("R8 high unchanged", d, 4);
        ictl = 8'h00;
        stop_and_idle();
        start_xfer();
        measure(0, 0, a, b, c, d, e, f);
        chk("R8 new low", a, 7);
        chk("R8 new high", d, 3);
        stop_and_idle();
    endtask

    task automatic t_disable();
        int a, b, c, d, e, f;
        int strobes, lows;
        lo_cnt_lsb = 8'd8; hi_cnt_lsb = 8'd8; ictl = 8'h00;
        start_xfer();
        repeat (3) tick();
        chan_en = 1'b0;
        tick();
        chk("R7 released after disable", scl_drive_low, 0);
        strobes = 0; lows = 0;
        for (int i = 0; i < 20; i++) begin
            if (drive_stb || sample_stb) strobes++;
            if (scl_drive_low) lows++;
            tick();
        end
        chk("R7 no strobes while disabled", strobes, 0);
        chk("R7 no low while disabled", lows, 0);
        chan_en = 1'b1;
        start_xfer();
        measure(0, 0, a, b, c, d, e, f);
        chk("R7 fresh low after enable", a, 8);
        chk("R7 fresh high after enable", d, 8);
    endtask

    task automatic t_idle();
        int strobes, lows;
        stop_and_idle();
        strobes = 0; lows = 0;
        for (int i = 0; i < 30; i++) begin
            if (drive_stb || sample_stb) strobes++;
            if (scl_drive_low) lows++;
            tick();
        end
        chk("R9 idle strobes", strobes, 0);
        chk("R9 idle scl released", lows, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        chan_en = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_nine_bit();
        t_clamp();
        t_stretch();
        t_hold();
        t_capture();
        t_disable();
        t_idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule